// File: doc/BRIEF.md
# Cascaded Interrupt Resolver with Acknowledge Vectoring

This block joins two eight-line priority resolvers, a primary and a secondary, into one sixteen-line interrupt system. Request line n is handled by resolver n/8 at its local line n mod 8. Whenever the secondary resolver has a request that beats its in-service state, that fact is captured as a rising edge on the primary's line 2, which is reserved for the cascade. The block drives one interrupt line towards the processor. That line is high whenever the primary has a winning request.

When the processor pulses the acknowledge input, the block updates the pending and in-service state of the resolver that owns the winning line. One clock later it presents an 8-bit vector with a one-cycle valid strobe. The vector is the owning resolver's base with its three low bits cleared, plus the local line number. Each resolver has its own auto-EOI and rotate-on-auto-EOI flags. Each request line has its own trigger-mode bit. Command decoding and end-of-interrupt commands are handled elsewhere. Without auto-EOI, in-service bits stay set until reset.

Top module: `irq_cascade`

## Requirements
- R1: Request line n (0..15) is resolved by the primary (n < 8) or the secondary (n >= 8) at local line n mod 8. The vector low three bits carry that local line.
- R2: A line whose trigger bit is 0 becomes pending on a 0-to-1 transition only. Acknowledging it clears the pending bit, and a line that stays high does not become pending again.
- R3: A line whose trigger bit is 1 is pending exactly while its input is high. Acknowledging it leaves it pending.
- R4: Among pending lines, the winner is the first line met when counting upward (mod 8) from the rotation base, which is 0 after reset. A pending line wins only if no in-service line comes at or before it in that order.
- R5: With auto-EOI off, acknowledging sets the in-service bit of the winning line. This blocks that line and every line after it in priority order.
- R6: With auto-EOI on, no in-service bit is set. If rotate-on-auto-EOI is also on, the rotation base becomes (acknowledged line + 1) mod 8.
- R7: Primary line 2 is fed only by the secondary's winner. irq_in[2] and trig_level[2] have no effect. When line 2 wins, the secondary is acknowledged and the vector is the secondary base plus its winning line.
- R8: An acknowledge while the primary has no winner returns the primary base plus 7 and changes no state.
- R9: If primary line 2 wins but the secondary has no winner, the vector is the secondary base plus 7.
- R10: Bits 2:0 of each base input are ignored (vector = (base AND 0xF8) + line).
- R11: vec_valid pulses high for exactly the cycle after each acknowledge, and vec holds the vector from then on.
- R12: int_out is high exactly while the primary has a winning request. It reflects each acknowledge from the following cycle.
- R13: After reset, int_out and vec_valid are low and no line is pending or in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Request lines |
| trig_level | input | 16 | Per-line trigger mode: 1 level, 0 edge |
| ack | input | 1 | Acknowledge strobe from the processor |
| master_base | input | 8 | Primary vector base |
| slave_base | input | 8 | Secondary vector base |
| auto_eoi | input | 2 | Auto-EOI enable, bit 0 primary, bit 1 secondary |
| rot_aeoi | input | 2 | Rotate on auto-EOI, bit 0 primary, bit 1 secondary |
| int_out | output | 1 | Interrupt request to the processor |
| vec | output | 8 | Acknowledged vector |
| vec_valid | output | 1 | One-cycle strobe marking vec |

## Verification
A request edge reaches the pending state at the next clock edge, so a primary line raises int_out one cycle after its input rises. A secondary line takes two cycles, because the cascade edge is captured one register later. The vector and its strobe are registered and appear one cycle after the acknowledge. The effect of the acknowledge on int_out shows in that same cycle. The bench drives inputs on the falling edge and steps a reference model once per clock. It samples every output at the following falling edge, which is exactly where each of these results is due.

// File: rtl/irq_casc_pkg.sv
package irq_casc_pkg;
  localparam int LINES   = 8;
  localparam int LINE_W  = $clog2(LINES);
  localparam int VEC_W   = 8;
  localparam int NCTL    = 2;
  localparam int CASC    = 2;

  typedef logic [LINE_W-1:0] line_t;

  typedef struct packed {
    logic  hit;
    line_t line;
  } win_t;

  // First pending line counted upward from base, granted only when it comes
  // strictly before every in-service line in the same order.
  function automatic win_t pick(input logic [LINES-1:0] pend,
                                input logic [LINES-1:0] busy,
                                input line_t base);
    int    pp;
    int    cp;
    line_t l;
    win_t  r;
    pp = LINES;
    cp = LINES;
    for (int k = LINES - 1; k >= 0; k--) begin
      l = base + line_t'(k);
      if (pend[l]) pp = k;
      if (busy[l]) cp = k;
    end
    r.hit  = (pp < cp);
    r.line = base + line_t'(pp);
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input logic [VEC_W-1:0] base,
                                              input line_t l);
    logic [VEC_W-1:0] keep;
    keep = {{(VEC_W-LINE_W){1'b1}}, {LINE_W{1'b0}}};
    return (base & keep) + VEC_W'(l);
  endfunction
endpackage

// File: rtl/irq_unit.sv
module irq_unit
  import irq_casc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req,
  input  logic [LINES-1:0] lvl,
  input  logic [LINES-1:0] inject,
  input  logic             aeoi,
  input  logic             rot_aeoi,
  input  logic             ack_i,
  output logic             win_hit,
  output line_t            win_line
);
  logic [LINES-1:0] last_q, irr_q, isr_q, irr_d;
  logic [LINES-1:0] take_mask, clr;
  line_t            padd_q;
  win_t             w;

  assign w         = pick(irr_q, isr_q, padd_q);
  assign win_hit   = w.hit;
  assign win_line  = w.line;
  assign take_mask = ack_i ? (LINES'(1) << w.line) : '0;
  assign clr       = take_mask & ~lvl;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign irr_d[g] = (lvl[g] ? req[g]
                              : ((irr_q[g] & ~clr[g]) | (req[g] & ~last_q[g])))
                      | inject[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= '0;
      irr_q  <= '0;
      isr_q  <= '0;
      padd_q <= '0;
    end else begin
      last_q <= req;
      irr_q  <= irr_d;
      if (ack_i && !aeoi) isr_q <= isr_q | take_mask;
      if (ack_i && aeoi && rot_aeoi) padd_q <= w.line + line_t'(1);
    end
  end

  // ack is only routed to a unit that holds a winner
  p_ack_has_win_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |-> win_hit);
  p_isr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !aeoi) |=> isr_q[$past(w.line)]);
  p_rotate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && aeoi && rot_aeoi) |=> (padd_q == $past(w.line) + line_t'(1)));
  p_aeoi_no_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && aeoi) |=> $stable(isr_q));
  p_level_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && lvl[w.line] && req[w.line]) |=> irr_q[$past(w.line)]);
endmodule

// File: rtl/irq_cascade.sv
module irq_cascade
  import irq_casc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCTL*LINES-1:0]  irq_in,
  input  logic [NCTL*LINES-1:0]  trig_level,
  input  logic                   ack,
  input  logic [VEC_W-1:0]       master_base,
  input  logic [VEC_W-1:0]       slave_base,
  input  logic [NCTL-1:0]        auto_eoi,
  input  logic [NCTL-1:0]        rot_aeoi,
  output logic                   int_out,
  output logic [VEC_W-1:0]       vec,
  output logic                   vec_valid
);
  localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASC;

  logic [LINES-1:0] c_req [NCTL];
  logic [LINES-1:0] c_lvl [NCTL];
  logic [LINES-1:0] c_inj [NCTL];
  logic             c_ack [NCTL];
  logic             c_hit [NCTL];
  line_t            c_line[NCTL];
  logic             casc_win;
  logic [VEC_W-1:0] vec_d;

  assign casc_win = c_hit[0] && (c_line[0] == line_t'(CASC));
  assign c_ack[0] = ack && c_hit[0];
  assign c_ack[1] = c_ack[0] && casc_win && c_hit[1];

  always_comb begin
    c_req[0] = irq_in[LINES-1:0] & ~CASC_BIT;
    c_lvl[0] = trig_level[LINES-1:0] & ~CASC_BIT;
    c_inj[0] = (c_hit[1] && !c_ack[1]) ? CASC_BIT : '0;
    c_req[1] = irq_in[2*LINES-1:LINES];
    c_lvl[1] = trig_level[2*LINES-1:LINES];
    c_inj[1] = '0;
  end

  for (genvar c = 0; c < NCTL; c++) begin : g_ctl
    irq_unit u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (c_req[c]),
      .lvl      (c_lvl[c]),
      .inject   (c_inj[c]),
      .aeoi     (auto_eoi[c]),
      .rot_aeoi (rot_aeoi[c]),
      .ack_i    (c_ack[c]),
      .win_hit  (c_hit[c]),
      .win_line (c_line[c])
    );
  end

  always_comb begin
    if (!c_hit[0])
      vec_d = vec_of(master_base, line_t'(LINES-1));
    else if (casc_win)
      vec_d = vec_of(slave_base, c_hit[1] ? c_line[1] : line_t'(LINES-1));
    else
      vec_d = vec_of(master_base, c_line[0]);
  end

  assign int_out = c_hit[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec       <= '0;
    end else begin
      vec_valid <= ack;
      if (ack) vec <= vec_d;
    end
  end

  p_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);
  p_strobe_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !vec_valid);
  p_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_out) |=> (vec[LINE_W-1:0] == line_t'(LINES-1)));
  p_slave_via_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
    c_ack[1] |-> (c_ack[0] && casc_win));
endmodule

// File: tb/sim_irq_cascade.sv
module sim_irq_cascade;
  localparam int CLK_NS = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] irq_in = 0, trig_level = 0;
  logic        ack = 0;
  logic [7:0]  master_base = 0, slave_base = 0;
  logic [1:0]  auto_eoi = 0, rot_aeoi = 0;
  logic        int_out, vec_valid;
  logic [7:0]  vec;

  int nchk = 0, nfail = 0;
  bit done = 0;

  // reference state
  bit [7:0] m_last[2], m_irr[2], m_isr[2];
  bit [2:0] m_padd[2];
  bit       e_int, e_valid;
  bit [7:0] e_vec;

  irq_cascade u0 (.*);

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void resolve(input bit [7:0] pend, input bit [7:0] busy,
                                  input bit [2:0] base, output bit hit,
                                  output bit [2:0] line);
    int bp = 9, bi = 9;
    for (int l = 0; l < 8; l++) begin
      int rank = (l - base + 8) % 8;
      if (pend[l] && rank < bp) begin bp = rank; line = 3'(l); end
      if (busy[l] && rank < bi) bi = rank;
    end
    hit = (bp < bi);
  endfunction

  function automatic bit [7:0] mkvec(bit [7:0] b, bit [2:0] l);
    return {b[7:3], l};
  endfunction

  function automatic void model_clear();
    for (int c = 0; c < 2; c++) begin
      m_last[c] = 0; m_irr[c] = 0; m_isr[c] = 0; m_padd[c] = 0;
    end
  endfunction

  function automatic void model_step();
    bit mh, sh, am, as_;
    bit [2:0] ml, sl;
    resolve(m_irr[0], m_isr[0], m_padd[0], mh, ml);
    resolve(m_irr[1], m_isr[1], m_padd[1], sh, sl);
    e_valid = ack;
    if (ack) begin
      if (!mh) e_vec = mkvec(master_base, 7);
      else if (ml == 2) e_vec = mkvec(slave_base, sh ? sl : 3'd7);
      else e_vec = mkvec(master_base, ml);
    end
    am  = ack && mh;
    as_ = am && ml == 2 && sh;
    for (int c = 0; c < 2; c++) begin
      bit acked = c == 0 ? am : as_;
      bit [2:0] wl = c == 0 ? ml : sl;
      bit [7:0] ni;
      for (int l = 0; l < 8; l++) begin
        bit rq = irq_in[c*8+l], lv = trig_level[c*8+l], inj = 0, clr;
        if (c == 0 && l == 2) begin rq = 0; lv = 0; inj = sh && !as_; end
        clr = acked && wl == l && !lv;
        if (lv) ni[l] = rq;
        else ni[l] = (m_irr[c][l] && !clr) || (rq && !m_last[c][l]);
        ni[l] |= inj;
        m_last[c][l] = rq;
      end
      m_irr[c] = ni;
      if (acked && !auto_eoi[c]) m_isr[c][wl] = 1;
      if (acked && auto_eoi[c] && rot_aeoi[c]) m_padd[c] = wl + 3'd1;
    end
    resolve(m_irr[0], m_isr[0], m_padd[0], e_int, ml);
  endfunction

  // one clock: inputs already set at negedge; sample at next negedge
  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R12 int_out", int_out, e_int);
    chk("R11 vec_valid", vec_valid, e_valid);
    if (e_valid) chk("R1 vec", vec, e_vec);
    ack = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; irq_in = 0; ack = 0;
    model_clear();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R13 reset state
    chk("R13 int_out after reset", int_out, 0);
    chk("R13 vec_valid after reset", vec_valid, 0);

    // R10 / R2 / R11 / R8 : edge line 5, odd bases
    master_base = 8'h27; slave_base = 8'h4D;
    irq_in[5] = 1; step();
    chk("R2 edge pends", int_out, 1);
    ack = 1; step();
    chk("R10 base low bits ignored", vec, 8'h25);
    chk("R11 strobe high", vec_valid, 1);
    chk("R5 in-service blocks", int_out, 0);
    step();
    chk("R11 strobe single cycle", vec_valid, 0);
    step(); step();
    chk("R2 held high no repend", int_out, 0);
    ack = 1; step();
    chk("R8 spurious primary", vec, 8'h27);

    // R7 cascade from secondary line 5 (irq 13)
    do_reset(); master_base = 8'h20; slave_base = 8'h48;
    irq_in[13] = 1; step();
    chk("R7 secondary needs two cycles", int_out, 0);
    step();
    chk("R7 cascade raises int", int_out, 1);
    ack = 1; step();
    chk("R7 secondary vector", vec, 8'h4D);

    // R7 irq_in[2] ignored, even level
    do_reset(); trig_level[2] = 1; irq_in[2] = 1;
    step(); step(); step();
    chk("R7 irq_in[2] no effect", int_out, 0);
    trig_level = 0;

    // R9 secondary spurious: level line 3 dropped
    do_reset(); trig_level[11] = 1; irq_in[11] = 1;
    step(); step();
    irq_in[11] = 0; step(); step();
    chk("R9 line 2 still pending", int_out, 1);
    ack = 1; step();
    chk("R9 secondary spurious", vec, 8'h4F);
    trig_level = 0;

    // R3 level line stays pending across acks (auto-EOI on)
    do_reset(); auto_eoi = 2'b01; trig_level[4] = 1; irq_in[4] = 1;
    step();
    ack = 1; step();
    chk("R3 level first ack", vec, 8'h24);
    chk("R3 still pending", int_out, 1);
    ack = 1; step();
    chk("R3 level second ack", vec, 8'h24);
    trig_level = 0;

    // R4 / R6 rotation on auto-EOI
    do_reset(); auto_eoi = 2'b01; rot_aeoi = 2'b01;
    irq_in[1] = 1; irq_in[3] = 1; step();
    ack = 1; step();
    chk("R4 lowest wins", vec, 8'h21);
    irq_in[0] = 1; step();
    ack = 1; step();
    chk("R6 rotated base favours 3", vec, 8'h23);
    auto_eoi = 0; rot_aeoi = 0;

    // R5 in-service blocks later lines, not earlier ones
    do_reset(); irq_in[4] = 1; step();
    ack = 1; step();
    chk("R5 vector", vec, 8'h24);
    irq_in[6] = 1; step(); step();
    chk("R5 lower line blocked", int_out, 0);
    irq_in[1] = 1; step();
    chk("R5 higher line passes", int_out, 1);
    ack = 1; step();
    chk("R5 higher vector", vec, 8'h21);

    // random phases
    for (int ph = 0; ph < 24; ph++) begin
      do_reset();
      trig_level  = 16'($urandom);
      auto_eoi    = 2'($urandom);
      rot_aeoi    = 2'($urandom);
      master_base = 8'($urandom);
      slave_base  = 8'($urandom);
      for (int cy = 0; cy < 250; cy++) begin
        for (int b = 0; b < 16; b++)
          if ($urandom_range(7) == 0) irq_in[b] = ~irq_in[b];
        ack = ($urandom_range(3) == 0);
        step();
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule